// File: doc/BRIEF.md
# Dual-Port Host/Device Mailbox Register File

This block is a small register file reached from two independent 8-bit bus slave ports that follow the Wishbone classic handshake. One port serves a host bridge and the other serves on-chip device logic. Each port has a 3-bit address and acknowledges every strobe after one clock. Both ports see the same eight byte registers at the same addresses, but the rules differ per register and per side.

The host drives a control byte that holds the device in reset and hands ownership of an external memory to the host. A flag byte carries interrupts from host to device: the host sets bits and the device clears them. A mailbox byte, an LED/switch byte and four seven-segment digit bytes are shared by both sides. The block also scans the four digits onto one set of active-low segment and anode pins.

Top module: `mbx_dual_regs`

## Requirements
- R1: On each port, a strobe with cycle active is accepted in the clock in which it is seen. The acknowledge goes high for exactly one clock on the following edge, and the read data is valid while it is high. The addresses are 0 control, 1 flags, 2 mailbox, 3 switch/LED, 4 to 7 digits 0 to 3.
- R2: The control byte is readable and writable from the host and readable from the device; a device write to it has no effect. `dev_reset_o` is the OR of control bit 7 and `rst`. `host_mem_o` follows control bit 6, where 1 means the host owns memory.
- R3: A host write to the flag byte sets each flag whose data bit is 1 and leaves flags written with 0 unchanged; `irq_flags_o` shows the flags.
- R4: A device write to the flag byte clears each flag whose data bit is 1 and leaves the others unchanged.
- R5: When a host set and a device clear hit the same flag in the same clock, the flag ends up set.
- R6: The mailbox byte can be written and read by both ports.
- R7: A read of address 3 returns `switch_i` after a two-flop synchronizer, valid three clocks after the input changes. A write to address 3 from either port drives `led_o`.
- R8: When both ports write the same shared register in the same clock, the host value is stored.
- R9: Reset clears every register. After reset `led_o`, `irq_flags_o`, `host_mem_o`, `seg_n_o` and `dp_n_o` are 0, so every segment is lit, and digit 0 is enabled.
- R10: Digits 0, 1, 2, 3 are enabled in turn, each for REFRESH_DIV clocks, by driving their bit of `anode_n_o` low (bit k for digit k, one bit at a time). `seg_n_o` carries bits 6:0 of the enabled digit byte: bit 0 top, 1 upper right, 2 lower right, 3 bottom, 4 lower left, 5 upper left, 6 middle. `dp_n_o` carries its bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cyc_i | input | 1 | Host bus cycle |
| h_stb_i | input | 1 | Host strobe |
| h_we_i | input | 1 | Host write enable |
| h_adr_i | input | 3 | Host register address |
| h_dat_i | input | 8 | Host write data |
| h_dat_o | output | 8 | Host read data |
| h_ack_o | output | 1 | Host acknowledge |
| d_cyc_i | input | 1 | Device bus cycle |
| d_stb_i | input | 1 | Device strobe |
| d_we_i | input | 1 | Device write enable |
| d_adr_i | input | 3 | Device register address |
| d_dat_i | input | 8 | Device write data |
| d_dat_o | output | 8 | Device read data |
| d_ack_o | output | 1 | Device acknowledge |
| dev_reset_o | output | 1 | Reset to the device logic |
| host_mem_o | output | 1 | Memory owned by host when 1 |
| irq_flags_o | output | 8 | Host-to-device flags |
| switch_i | input | 8 | Asynchronous switch inputs |
| led_o | output | 8 | LED drive |
| seg_n_o | output | 7 | Active-low segments of the enabled digit |
| dp_n_o | output | 1 | Active-low decimal point |
| anode_n_o | output | 4 | Active-low digit enables |

## Verification
The assertions assume that each master keeps its strobe high only until it sees its acknowledge. They also assume that the address and write data are steady while the strobe is high and that `rst` is held for at least one clock. The stimulus opens every access on a falling edge, drops the strobe on the falling edge where the acknowledge is seen, and changes `switch_i` only between accesses. Same-clock collisions on the flags and the shared bytes are made by starting both ports on the same falling edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADR_W       = 3;
    localparam int NUM_DIGITS  = 4;
    localparam int SEG_W       = 7;
    localparam int CTRL_RST_B  = 7;
    localparam int CTRL_OWN_B  = 6;

    typedef enum logic [ADR_W-1:0] {
        A_CTRL  = 3'd0,
        A_FLAGS = 3'd1,
        A_MBOX  = 3'd2,
        A_IO    = 3'd3,
        A_DIG0  = 3'd4,
        A_DIG1  = 3'd5,
        A_DIG2  = 3'd6,
        A_DIG3  = 3'd7
    } mbx_addr_e;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t                   ctrl;
        byte_t                   flags;
        byte_t                   mbox;
        byte_t                   led;
        byte_t [NUM_DIGITS-1:0]  digit;
    } mbx_file_t;

    typedef struct packed {
        logic             wr;
        logic [ADR_W-1:0] adr;
        byte_t            dat;
    } mbx_wreq_t;

    function automatic byte_t mbx_read(mbx_file_t f, byte_t sw, logic [ADR_W-1:0] adr);
        case (adr)
            A_CTRL:  return f.ctrl;
            A_FLAGS: return f.flags;
            A_MBOX:  return f.mbox;
            A_IO:    return sw;
            default: return f.digit[adr - A_DIG0];
        endcase
    endfunction

    function automatic logic hits(mbx_wreq_t r, logic [ADR_W-1:0] adr);
        return r.wr && (r.adr == adr);
    endfunction

endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            sync_o <= '0;
        end else begin
            meta   <= async_i;
            sync_o <= meta;
        end
    end
endmodule

// File: rtl/mbx_wb_port.sv
module mbx_wb_port
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [ADR_W-1:0] adr_i,
    input  byte_t            dat_i,
    input  mbx_file_t        file_i,
    input  byte_t            sw_i,
    output byte_t            dat_o,
    output logic             ack_o,
    output mbx_wreq_t        wreq_o
);
    logic accept;

    assign accept = cyc_i && stb_i && !ack_o;
    assign wreq_o = '{wr: accept && we_i, adr: adr_i, dat: dat_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= accept;
            if (accept) dat_o <= mbx_read(file_i, sw_i, adr_i);
        end
    end

    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R1
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(cyc_i && stb_i));
endmodule

// File: rtl/mbx_digit_scan.sv
module mbx_digit_scan
    import mbx_pkg::*;
#(
    parameter int N_DIG = NUM_DIGITS,
    parameter int DIV   = 100000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  byte_t [N_DIG-1:0]       digit_i,
    output logic  [SEG_W-1:0]       seg_n_o,
    output logic                    dp_n_o,
    output logic  [N_DIG-1:0]       anode_n_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int IW = (N_DIG > 1) ? $clog2(N_DIG) : 1;

    logic [CW-1:0] tick_cnt;
    logic [IW-1:0] sel;
    logic          wrap;

    assign wrap = (tick_cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            sel      <= '0;
        end else if (wrap) begin
            tick_cnt <= '0;
            sel      <= (sel == IW'(N_DIG - 1)) ? '0 : sel + 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < N_DIG; k++) begin : g_anode
        assign anode_n_o[k] = !(sel == IW'(k));
    end

    assign seg_n_o = digit_i[sel][SEG_W-1:0];
    assign dp_n_o  = digit_i[sel][SEG_W];

    // R10
    anode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~anode_n_o) == 1);

    // R10
    anode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wrap) && !$past(rst) |-> $stable(anode_n_o));
endmodule

// File: rtl/mbx_dual_regs.sv
module mbx_dual_regs
    import mbx_pkg::*;
#(
    parameter int REFRESH_DIV = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_cyc_i,
    input  logic             h_stb_i,
    input  logic             h_we_i,
    input  logic [2:0]       h_adr_i,
    input  logic [7:0]       h_dat_i,
    output logic [7:0]       h_dat_o,
    output logic             h_ack_o,
    input  logic             d_cyc_i,
    input  logic             d_stb_i,
    input  logic             d_we_i,
    input  logic [2:0]       d_adr_i,
    input  logic [7:0]       d_dat_i,
    output logic [7:0]       d_dat_o,
    output logic             d_ack_o,
    output logic             dev_reset_o,
    output logic             host_mem_o,
    output logic [7:0]       irq_flags_o,
    input  logic [7:0]       switch_i,
    output logic [7:0]       led_o,
    output logic [6:0]       seg_n_o,
    output logic             dp_n_o,
    output logic [3:0]       anode_n_o
);
    mbx_file_t file_q;
    mbx_wreq_t hreq, dreq;
    byte_t     sw_sync;
    byte_t     flag_set, flag_clr;

    mbx_sync2 #(.W(BYTE_W)) u_sw_sync (
        .clk(clk), .rst(rst), .async_i(switch_i), .sync_o(sw_sync));

    mbx_wb_port u_host_port (
        .clk(clk), .rst(rst), .cyc_i(h_cyc_i), .stb_i(h_stb_i), .we_i(h_we_i),
        .adr_i(h_adr_i), .dat_i(h_dat_i), .file_i(file_q), .sw_i(sw_sync),
        .dat_o(h_dat_o), .ack_o(h_ack_o), .wreq_o(hreq));

    mbx_wb_port u_dev_port (
        .clk(clk), .rst(rst), .cyc_i(d_cyc_i), .stb_i(d_stb_i), .we_i(d_we_i),
        .adr_i(d_adr_i), .dat_i(d_dat_i), .file_i(file_q), .sw_i(sw_sync),
        .dat_o(d_dat_o), .ack_o(d_ack_o), .wreq_o(dreq));

    assign flag_set = hits(hreq, A_FLAGS) ? hreq.dat : '0;
    assign flag_clr = hits(dreq, A_FLAGS) ? dreq.dat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            file_q <= '0;
        end else begin
            if (hits(hreq, A_CTRL)) file_q.ctrl <= hreq.dat;
            file_q.flags <= (file_q.flags & ~flag_clr) | flag_set;
            if (hits(hreq, A_MBOX))      file_q.mbox <= hreq.dat;
            else if (hits(dreq, A_MBOX)) file_q.mbox <= dreq.dat;
            if (hits(hreq, A_IO))        file_q.led  <= hreq.dat;
            else if (hits(dreq, A_IO))   file_q.led  <= dreq.dat;
            for (int k = 0; k < NUM_DIGITS; k++) begin
                if (hits(hreq, A_DIG0 + ADR_W'(k)))
                    file_q.digit[k] <= hreq.dat;
                else if (hits(dreq, A_DIG0 + ADR_W'(k)))
                    file_q.digit[k] <= dreq.dat;
            end
        end
    end

    assign dev_reset_o = rst || file_q.ctrl[CTRL_RST_B];
    assign host_mem_o  = file_q.ctrl[CTRL_OWN_B];
    assign irq_flags_o = file_q.flags;
    assign led_o       = file_q.led;

    mbx_digit_scan #(.N_DIG(NUM_DIGITS), .DIV(REFRESH_DIV)) u_scan (
        .clk(clk), .rst(rst), .digit_i(file_q.digit),
        .seg_n_o(seg_n_o), .dp_n_o(dp_n_o), .anode_n_o(anode_n_o));

    // R2
    always_comb begin
        if (rst) dev_reset_hold_chk: assert (dev_reset_o);
    end

    // R2
    ctrl_dev_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !(h_cyc_i && h_stb_i && h_we_i && h_adr_i == 3'd0) |=> $stable(host_mem_o));

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (h_cyc_i && h_stb_i && !h_ack_o && h_we_i && h_adr_i == 3'd1)
        |=> ((irq_flags_o & $past(h_dat_i)) == $past(h_dat_i)));

    // R4
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (d_cyc_i && d_stb_i && !d_ack_o && d_we_i && d_adr_i == 3'd1 &&
         !(h_cyc_i && h_stb_i && h_we_i && h_adr_i == 3'd1))
        |=> ((irq_flags_o & $past(d_dat_i)) == 8'h00));

    // R8
    led_host_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (h_cyc_i && h_stb_i && !h_ack_o && h_we_i && h_adr_i == 3'd3 &&
         d_cyc_i && d_stb_i && d_we_i && d_adr_i == 3'd3)
        |=> (led_o == $past(h_dat_i)));
endmodule

// File: tb/tb_mbx_dual_regs.sv
module tb_mbx_dual_regs;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_cyc = 0, h_stb = 0, h_we = 0;
    logic [2:0] h_adr = 0;
    logic [7:0] h_wd = 0;
    logic [7:0] h_rd;
    logic       h_ack;
    logic       d_cyc = 0, d_stb = 0, d_we = 0;
    logic [2:0] d_adr = 0;
    logic [7:0] d_wd = 0;
    logic [7:0] d_rd;
    logic       d_ack;
    logic       dev_reset, host_mem;
    logic [7:0] flags, leds;
    logic [7:0] sw = 0;
    logic [6:0] seg_n;
    logic       dp_n;
    logic [3:0] anode_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbx_dual_regs #(.REFRESH_DIV(DIV)) dut (
        .clk(clk), .rst(rst),
        .h_cyc_i(h_cyc), .h_stb_i(h_stb), .h_we_i(h_we), .h_adr_i(h_adr),
        .h_dat_i(h_wd), .h_dat_o(h_rd), .h_ack_o(h_ack),
        .d_cyc_i(d_cyc), .d_stb_i(d_stb), .d_we_i(d_we), .d_adr_i(d_adr),
        .d_dat_i(d_wd), .d_dat_o(d_rd), .d_ack_o(d_ack),
        .dev_reset_o(dev_reset), .host_mem_o(host_mem), .irq_flags_o(flags),
        .switch_i(sw), .led_o(leds), .seg_n_o(seg_n), .dp_n_o(dp_n),
        .anode_n_o(anode_n));

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_xfer(bit we, logic [2:0] adr, logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        h_cyc = 1; h_stb = 1; h_we = we; h_adr = adr; h_wd = wd;
        check("R1 host ack low at strobe", h_ack, 0);
        @(negedge clk);
        check("R1 host ack one clock later", h_ack, 1);
        rd = h_rd;
        h_cyc = 0; h_stb = 0; h_we = 0;
        @(negedge clk);
        check("R1 host ack single pulse", h_ack, 0);
    endtask

    task automatic dev_xfer(bit we, logic [2:0] adr, logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        d_cyc = 1; d_stb = 1; d_we = we; d_adr = adr; d_wd = wd;
        check("R1 dev ack low at strobe", d_ack, 0);
        @(negedge clk);
        check("R1 dev ack one clock later", d_ack, 1);
        rd = d_rd;
        d_cyc = 0; d_stb = 0; d_we = 0;
        @(negedge clk);
        check("R1 dev ack single pulse", d_ack, 0);
    endtask

    task automatic both_write(logic [2:0] ha, logic [7:0] hd, logic [2:0] da, logic [7:0] dd);
        @(negedge clk);
        h_cyc = 1; h_stb = 1; h_we = 1; h_adr = ha; h_wd = hd;
        d_cyc = 1; d_stb = 1; d_we = 1; d_adr = da; d_wd = dd;
        @(negedge clk);
        check("R1 both acks", {h_ack, d_ack}, 2'b11);
        h_cyc = 0; h_stb = 0; h_we = 0;
        d_cyc = 0; d_stb = 0; d_we = 0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R9 led after reset", leds, 8'h00);
        check("R9 flags after reset", flags, 8'h00);
        check("R9 host_mem after reset", host_mem, 0);
        check("R9 dev_reset after reset", dev_reset, 0);
        check("R9 all segments lit", {dp_n, seg_n}, 8'h00);
        check("R9 digit0 enabled", anode_n, 4'b1110);
        check("R9 acks idle", {h_ack, d_ack}, 2'b00);
    endtask

    task automatic t_ctrl();
        logic [7:0] rd;
        host_xfer(1, 3'd0, 8'h80, rd);
        check("R2 dev_reset from bit7", dev_reset, 1);
        check("R2 host_mem clear", host_mem, 0);
        dev_xfer(0, 3'd0, 8'h00, rd);
        check("R2 device reads ctrl", rd, 8'h80);
        dev_xfer(1, 3'd0, 8'h40, rd);
        host_xfer(0, 3'd0, 8'h00, rd);
        check("R2 device write ignored", rd, 8'h80);
        check("R2 host_mem unchanged by device", host_mem, 0);
        host_xfer(1, 3'd0, 8'h40, rd);
        check("R2 host_mem from bit6", host_mem, 1);
        check("R2 dev_reset released", dev_reset, 0);
    endtask

    task automatic t_flags();
        logic [7:0] rd;
        host_xfer(1, 3'd1, 8'h05, rd);
        check("R3 host sets flags", flags, 8'h05);
        host_xfer(1, 3'd1, 8'h10, rd);
        check("R3 zero bits keep flags", flags, 8'h15);
        dev_xfer(1, 3'd1, 8'h04, rd);
        check("R4 device clears flag", flags, 8'h11);
        dev_xfer(0, 3'd1, 8'h00, rd);
        check("R4 device reads flags", rd, 8'h11);
        both_write(3'd1, 8'h01, 3'd1, 8'h01);
        check("R5 set wins over clear", flags, 8'h11);
        both_write(3'd1, 8'h02, 3'd1, 8'h10);
        check("R5 set and clear on other bits", flags, 8'h03);
    endtask

    task automatic t_mbox();
        logic [7:0] rd;
        host_xfer(1, 3'd2, 8'hA5, rd);
        dev_xfer(0, 3'd2, 8'h00, rd);
        check("R6 device reads host value", rd, 8'hA5);
        dev_xfer(1, 3'd2, 8'h3C, rd);
        host_xfer(0, 3'd2, 8'h00, rd);
        check("R6 host reads device value", rd, 8'h3C);
    endtask

    task automatic t_io();
        logic [7:0] rd;
        sw = 8'h6B;
        repeat (3) @(negedge clk);
        host_xfer(0, 3'd3, 8'h00, rd);
        check("R7 host reads switches", rd, 8'h6B);
        dev_xfer(0, 3'd3, 8'h00, rd);
        check("R7 device reads switches", rd, 8'h6B);
        host_xfer(1, 3'd3, 8'h81, rd);
        check("R7 host drives leds", leds, 8'h81);
        dev_xfer(1, 3'd3, 8'h7E, rd);
        check("R7 device drives leds", leds, 8'h7E);
        host_xfer(0, 3'd3, 8'h00, rd);
        check("R7 led write leaves switch read", rd, 8'h6B);
    endtask

    task automatic t_priority();
        logic [7:0] rd;
        both_write(3'd2, 8'h11, 3'd2, 8'h22);
        host_xfer(0, 3'd2, 8'h00, rd);
        check("R8 host wins mailbox", rd, 8'h11);
        both_write(3'd3, 8'h55, 3'd3, 8'hAA);
        check("R8 host wins led", leds, 8'h55);
        both_write(3'd5, 8'h0F, 3'd5, 8'hF0);
        dev_xfer(0, 3'd5, 8'h00, rd);
        check("R8 host wins digit", rd, 8'h0F);
    endtask

    task automatic t_scan();
        logic [7:0] rd;
        logic [7:0] pat [4];
        pat[0] = 8'hFE; pat[1] = 8'h7F; pat[2] = 8'hC0; pat[3] = 8'hB6;
        host_xfer(1, 3'd4, pat[0], rd);
        host_xfer(1, 3'd5, pat[1], rd);
        dev_xfer(1, 3'd6, pat[2], rd);
        dev_xfer(1, 3'd7, pat[3], rd);
        for (int g = 0; g < 40 && anode_n != 4'b1110; g++) @(negedge clk);
        for (int g = 0; g < 40 && anode_n == 4'b1110; g++) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            int k = (s + 1) % 4;
            logic [3:0] exp_an = ~(4'b0001 << k);
            int n = 0;
            check("R10 digit order", anode_n, exp_an);
            check("R10 segments of digit", {dp_n, seg_n}, pat[k]);
            for (int g = 0; g < 40 && anode_n == exp_an; g++) begin
                n++;
                @(negedge clk);
            end
            check("R10 digit dwell", n, DIV);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_ctrl();
        t_flags();
        t_mbox();
        t_io();
        t_priority();
        t_scan();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule